// File: doc/BRIEF.md
# Serial Channel Interrupt Bid Generator

This block collects the interrupt conditions of one serial channel and turns them into one request line and an arbitration bid number. An external arbiter compares these bids across channels. There are seven sources. Two of them are levels: the transmit queue needs service and the receive queue needs service. Four are single-cycle event strobes that the block latches: break detected, flow-control character recognised, address-recognition change and input change of state. The seventh is a built-in receiver-idle watchdog. It counts bit-time ticks and fires after 64 idle bit times.

An 8-bit mask register enables each source through the mask bit whose index equals the source code. Four 3-bit prefix registers let software rank the change-of-state, flow-character, break and address classes against the same classes on other channels. The request output and the bid are both registered. The host writes and reads the five registers through a simple port, and each read returns its data one cycle later. The host clears a latched source by pulsing the acknowledge bit that has the same index.

Top module: `uart_irq_bidder`

## Requirements
- R1: While rst is high and in the first cycle after it falls, irq_req is 0, irq_bid is 0 and host_rd_data is 0. Reset also clears all registers, pending state and the watchdog.
- R2: Source code 0 (tx_svc) and source code 1 (rx_svc) are levels. Each is sampled every cycle. When mask bit 0 or mask bit 1 is set, irq_req is high two clock edges after the level is applied, and it drops the same number of edges after the level is removed.
- R3: The strobes brk_evt (code 2), flow_evt (code 4), addr_evt (code 5) and cos_evt (code 7) each set a pending bit. That bit stays set until irq_ack has a 1 in the same bit position. If a strobe and an acknowledge for one source arrive in the same cycle, the strobe wins.
- R4: Mask bit 3 is stored and reads back, but it enables no source. Code 3 never appears in a bid. A pending source whose mask bit is 0 keeps its pending state and raises a request once its mask bit is set.
- R5: The bid is {prefix[2:0], code[2:0]}. The prefix comes from the register at address 1 for code 7, address 2 for code 4, address 3 for code 2, and address 4 for code 5. Codes 0, 1 and 6 use prefix 000.
- R6: When several enabled sources are pending, the bid carries the highest code among them.
- R7: The register map is: address 0 is the mask (all 8 bits); addresses 1 to 4 are prefix registers that store bits 2:0, with bits 7:3 always reading 0. Addresses 5 to 7 read 0. host_rd_data shows the register at host_addr one cycle later, and a write lands at the clock edge where host_wr is high.
- R8: The watchdog counts bit_tick pulses and is cleared by rx_activity; activity takes precedence over a tick in the same cycle. On the 64th tick with no intervening activity, it sets pending code 6 after one more edge. It does not fire again until new activity has occurred.
- R9: irq_req is high exactly when, one edge earlier, at least one enabled source was pending. When irq_req is low, irq_bid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Register write data |
| host_rd_data | output | 8 | Registered read data for host_addr |
| tx_svc | input | 1 | Transmit queue service level (code 0) |
| rx_svc | input | 1 | Receive queue service level (code 1) |
| brk_evt | input | 1 | Break change strobe (code 2) |
| flow_evt | input | 1 | Flow-control character strobe (code 4) |
| addr_evt | input | 1 | Address recognition change strobe (code 5) |
| cos_evt | input | 1 | Input change-of-state strobe (code 7) |
| bit_tick | input | 1 | One pulse per receiver bit time |
| rx_activity | input | 1 | Pulse per received character |
| irq_ack | input | 8 | Per-code clear of latched pending bits |
| irq_req | output | 1 | Interrupt request |
| irq_bid | output | 6 | Arbitration bid {prefix, code} |

## Verification
The assertions take for granted that reset is held for at least one edge before any property is evaluated. The persistence check for latched pending bits assumes that irq_ack is the only way to clear them, which holds because the bench changes no register by any other route. The stimulus drives every input on the falling edge and holds it for a full cycle, so each strobe lasts exactly one sampling edge. bit_tick pulses only in the watchdog phases, which keeps the idle count deterministic, and those phases include ticks that coincide with activity.

// File: rtl/irq_bid_pkg.sv
package irq_bid_pkg;
  localparam int NSRC      = 8;
  localparam int CODE_W    = 3;
  localparam int PFX_W     = 3;
  localparam int BID_W     = PFX_W + CODE_W;
  localparam int REG_W     = 8;
  localparam int ADDR_W    = 3;
  localparam int NPFX      = 4;

  localparam int SRC_TX    = 0;
  localparam int SRC_RX    = 1;
  localparam int SRC_BRK   = 2;
  localparam int SRC_RSVD  = 3;
  localparam int SRC_FLOW  = 4;
  localparam int SRC_ADDR  = 5;
  localparam int SRC_WDOG  = 6;
  localparam int SRC_COS   = 7;

  localparam logic [ADDR_W-1:0] A_MASK     = 3'd0;
  localparam logic [ADDR_W-1:0] A_PFX_BASE = 3'd1;

  // prefix register slots, ordered by address offset from A_PFX_BASE
  localparam int PS_COS  = 0;
  localparam int PS_FLOW = 1;
  localparam int PS_BRK  = 2;
  localparam int PS_ADDR = 3;

  typedef logic [PFX_W-1:0] pfx_t;
endpackage

// File: rtl/irq_host_regs.sv
module irq_host_regs
  import irq_bid_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mask_o,
  output pfx_t          pfx_o [NPFX],
  output logic [DW-1:0] rd_data
);
  localparam int PAD_W = DW - PFX_W;

  logic [DW-1:0] mask_q;
  pfx_t          pfx_q [NPFX];
  logic [DW-1:0] rd_next;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else if (wr && addr == A_MASK) mask_q <= wdata;
  end

  for (genvar g = 0; g < NPFX; g++) begin : g_pfx
    localparam logic [AW-1:0] MY_ADDR = AW'(int'(A_PFX_BASE) + g);
    always_ff @(posedge clk) begin
      if (rst) pfx_q[g] <= '0;
      else if (wr && addr == MY_ADDR) pfx_q[g] <= wdata[PFX_W-1:0];
    end
    assign pfx_o[g] = pfx_q[g];
  end

  always_comb begin
    rd_next = '0;
    if (addr == A_MASK) rd_next = mask_q;
    for (int i = 0; i < NPFX; i++) begin
      if (addr == AW'(int'(A_PFX_BASE) + i)) rd_next = {{PAD_W{1'b0}}, pfx_q[i]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_idle_watchdog.sv
module irq_idle_watchdog #(
  parameter int IDLE_BITS = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic rx_activity,
  output logic fire
);
  localparam int CW = $clog2(IDLE_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(IDLE_BITS - 1);

  logic [CW-1:0] cnt_q;
  logic          spent_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      spent_q <= 1'b0;
      fire    <= 1'b0;
    end else if (rx_activity) begin
      cnt_q   <= '0;
      spent_q <= 1'b0;
      fire    <= 1'b0;
    end else if (bit_tick && !spent_q) begin
      if (cnt_q == LAST) begin
        cnt_q   <= '0;
        spent_q <= 1'b1;
        fire    <= 1'b1;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
        fire    <= 1'b0;
      end
    end else begin
      fire <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_pending.sv
module irq_pending
  import irq_bid_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src_in,
  input  logic [N-1:0] ack,
  output logic [N-1:0] pend
);
  for (genvar g = 0; g < N; g++) begin : g_src
    if (g == SRC_TX || g == SRC_RX) begin : g_level
      always_ff @(posedge clk) begin
        if (rst) pend[g] <= 1'b0;
        else     pend[g] <= src_in[g];
      end
    end else if (g == SRC_RSVD) begin : g_none
      assign pend[g] = 1'b0;
    end else begin : g_latch
      always_ff @(posedge clk) begin
        if (rst)           pend[g] <= 1'b0;
        else if (src_in[g]) pend[g] <= 1'b1;
        else if (ack[g])   pend[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_bid_select.sv
module irq_bid_select
  import irq_bid_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  pend,
  input  logic [NSRC-1:0]  mask,
  input  pfx_t             pfx [NPFX],
  output logic             req,
  output logic [BID_W-1:0] bid
);
  localparam logic [NSRC-1:0] RSVD_OFF = ~(NSRC'(1) << SRC_RSVD);

  logic [NSRC-1:0]   live;
  logic [CODE_W-1:0] win;
  logic              any;
  pfx_t              win_pfx;

  assign live = pend & mask & RSVD_OFF;

  always_comb begin
    win = '0;
    any = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (live[i]) begin
        win = CODE_W'(i);
        any = 1'b1;
      end
    end
  end

  always_comb begin
    case (int'(win))
      SRC_COS:  win_pfx = pfx[PS_COS];
      SRC_FLOW: win_pfx = pfx[PS_FLOW];
      SRC_BRK:  win_pfx = pfx[PS_BRK];
      SRC_ADDR: win_pfx = pfx[PS_ADDR];
      default:  win_pfx = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req <= 1'b0;
      bid <= '0;
    end else begin
      req <= any;
      bid <= any ? {win_pfx, win} : '0;
    end
  end
endmodule

// File: rtl/uart_irq_bidder.sv
module uart_irq_bidder
  import irq_bid_pkg::*;
#(
  parameter int IDLE_BITS = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [REG_W-1:0] host_wdata,
  output logic [REG_W-1:0] host_rd_data,
  input  logic             tx_svc,
  input  logic             rx_svc,
  input  logic             brk_evt,
  input  logic             flow_evt,
  input  logic             addr_evt,
  input  logic             cos_evt,
  input  logic             bit_tick,
  input  logic             rx_activity,
  input  logic [NSRC-1:0]  irq_ack,
  output logic             irq_req,
  output logic [BID_W-1:0] irq_bid
);
  logic [REG_W-1:0] mask_q;
  pfx_t             pfx_w [NPFX];
  logic             wd_fire;
  logic [NSRC-1:0]  src_vec;
  logic [NSRC-1:0]  pend_q;

  irq_host_regs u_regs (
    .clk(clk), .rst(rst), .wr(host_wr), .addr(host_addr), .wdata(host_wdata),
    .mask_o(mask_q), .pfx_o(pfx_w), .rd_data(host_rd_data)
  );

  irq_idle_watchdog #(.IDLE_BITS(IDLE_BITS)) u_wdog (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .rx_activity(rx_activity),
    .fire(wd_fire)
  );

  always_comb begin
    src_vec           = '0;
    src_vec[SRC_TX]   = tx_svc;
    src_vec[SRC_RX]   = rx_svc;
    src_vec[SRC_BRK]  = brk_evt;
    src_vec[SRC_FLOW] = flow_evt;
    src_vec[SRC_ADDR] = addr_evt;
    src_vec[SRC_WDOG] = wd_fire;
    src_vec[SRC_COS]  = cos_evt;
  end

  irq_pending u_pend (
    .clk(clk), .rst(rst), .src_in(src_vec), .ack(irq_ack), .pend(pend_q)
  );

  irq_bid_select u_sel (
    .clk(clk), .rst(rst), .pend(pend_q), .mask(mask_q), .pfx(pfx_w),
    .req(irq_req), .bid(irq_bid)
  );
endmodule

// File: rtl/irq_bid_checker.sv
module irq_bid_checker
  import irq_bid_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             irq_req,
  input logic [BID_W-1:0] irq_bid,
  input logic [REG_W-1:0] mask,
  input logic [NSRC-1:0]  pend,
  input logic [NSRC-1:0]  ack,
  input logic             wd_fire,
  input logic [ADDR_W-1:0] host_addr,
  input logic [REG_W-1:0] host_rd_data
);
  AST_IDLE_BID_ZERO: assert property (@(posedge clk) disable iff (rst)
    !irq_req |-> irq_bid == '0); // R9

  AST_NO_RSVD_CODE: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> irq_bid[CODE_W-1:0] != CODE_W'(SRC_RSVD)); // R4

  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (rst)
    (($past(mask) & 8'hF7) == 8'h00) |-> !irq_req); // R2

  AST_WDOG_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wd_fire |=> !wd_fire); // R8

  AST_PFX_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(host_addr) >= 3'd1 && $past(host_addr) <= 3'd4) |-> host_rd_data[7:3] == 5'd0); // R7

  AST_BRK_HELD: assert property (@(posedge clk) disable iff (rst)
    ($past(pend[SRC_BRK]) && !$past(ack[SRC_BRK])) |-> pend[SRC_BRK]); // R3

  AST_COS_HELD: assert property (@(posedge clk) disable iff (rst)
    ($past(pend[SRC_COS]) && !$past(ack[SRC_COS])) |-> pend[SRC_COS]); // R3
endmodule

bind uart_irq_bidder irq_bid_checker u_chk (
  .clk(clk), .rst(rst), .irq_req(irq_req), .irq_bid(irq_bid), .mask(mask_q),
  .pend(pend_q), .ack(irq_ack), .wd_fire(wd_fire), .host_addr(host_addr),
  .host_rd_data(host_rd_data)
);

// File: tb/uart_irq_bidder_tb.sv
module uart_irq_bidder_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_wr = 1'b0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rd_data;
  logic tx_svc = 0, rx_svc = 0, brk_evt = 0, flow_evt = 0, addr_evt = 0, cos_evt = 0;
  logic bit_tick = 0, rx_activity = 0;
  logic [7:0] irq_ack = '0;
  logic irq_req;
  logic [5:0] irq_bid;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  uart_irq_bidder u_dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rd_data(host_rd_data), .tx_svc(tx_svc),
    .rx_svc(rx_svc), .brk_evt(brk_evt), .flow_evt(flow_evt), .addr_evt(addr_evt),
    .cos_evt(cos_evt), .bit_tick(bit_tick), .rx_activity(rx_activity),
    .irq_ack(irq_ack), .irq_req(irq_req), .irq_bid(irq_bid)
  );

  // behavioural reference model
  int m_mask, m_cnt;
  int m_pfx[8];          // indexed by source code
  bit m_pend[8];
  bit m_spent, m_fire;
  int e_req, e_bid, e_rd;

  always @(posedge clk) begin
    if (rst) begin
      m_mask = 0; m_cnt = 0; m_spent = 0; m_fire = 0;
      foreach (m_pfx[i]) m_pfx[i] = 0;
      foreach (m_pend[i]) m_pend[i] = 0;
      e_req = 0; e_bid = 0; e_rd = 0;
    end else begin
      int best;
      best = -1;
      for (int c = 0; c < 8; c++)
        if (c != 3 && m_pend[c] && m_mask[c]) best = c;
      e_req = (best >= 0);
      e_bid = (best >= 0) ? m_pfx[best] * 8 + best : 0;
      case (host_addr)
        3'd0: e_rd = m_mask;
        3'd1: e_rd = m_pfx[7];
        3'd2: e_rd = m_pfx[4];
        3'd3: e_rd = m_pfx[2];
        3'd4: e_rd = m_pfx[5];
        default: e_rd = 0;
      endcase
      m_pend[0] = tx_svc;
      m_pend[1] = rx_svc;
      m_pend[2] = brk_evt  | (m_pend[2] & !irq_ack[2]);
      m_pend[4] = flow_evt | (m_pend[4] & !irq_ack[4]);
      m_pend[5] = addr_evt | (m_pend[5] & !irq_ack[5]);
      m_pend[6] = m_fire   | (m_pend[6] & !irq_ack[6]);
      m_pend[7] = cos_evt  | (m_pend[7] & !irq_ack[7]);
      if (rx_activity) begin
        m_cnt = 0; m_spent = 0; m_fire = 0;
      end else if (bit_tick && !m_spent) begin
        m_cnt++;
        m_fire = (m_cnt == 64);
        if (m_fire) begin m_spent = 1; m_cnt = 0; end
      end else m_fire = 0;
      if (host_wr) begin
        case (host_addr)
          3'd0: m_mask = host_wdata;
          3'd1: m_pfx[7] = host_wdata & 7;
          3'd2: m_pfx[4] = host_wdata & 7;
          3'd3: m_pfx[2] = host_wdata & 7;
          3'd4: m_pfx[5] = host_wdata & 7;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      n_cmp++;
      if (irq_req !== e_req[0]) begin
        n_bad++; $display("FAIL R9/R2: irq_req=%0b expected %0d at %0t", irq_req, e_req, $time);
      end
      n_cmp++;
      if (irq_bid !== e_bid[5:0]) begin
        n_bad++; $display("FAIL R5/R6: irq_bid=%h expected %h at %0t", irq_bid, e_bid[5:0], $time);
      end
      n_cmp++;
      if (host_rd_data !== e_rd[7:0]) begin
        n_bad++; $display("FAIL R7: host_rd_data=%h expected %h at %0t", host_rd_data, e_rd[7:0], $time);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++; $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input int a, input int d);
    host_wr = 1; host_addr = 3'(a); host_wdata = 8'(d);
    step();
    host_wr = 0;
  endtask

  task automatic pulse_evt(input int code);
    case (code)
      2: brk_evt = 1; 4: flow_evt = 1; 5: addr_evt = 1; 7: cos_evt = 1; default: ;
    endcase
    step();
    brk_evt = 0; flow_evt = 0; addr_evt = 0; cos_evt = 0;
  endtask

  task automatic ack(input int bits);
    irq_ack = 8'(bits);
    step();
    irq_ack = '0;
  endtask

  initial begin
    step(3);
    // R1: outputs idle during reset
    chk("R1", {irq_req, irq_bid, host_rd_data}, 0);
    rst = 0;
    step();
    chk("R1", {irq_req, irq_bid, host_rd_data}, 0);

    // R7: register map, upper prefix bits read zero, unmapped reads zero
    wreg(1, 8'hFD); wreg(2, 8'h13); wreg(3, 8'hA2); wreg(4, 8'h0E);
    host_addr = 3'd1; step(); chk("R7", host_rd_data, 8'h05);
    host_addr = 3'd4; step(); chk("R7", host_rd_data, 8'h06);
    host_addr = 3'd6; step(); chk("R7", host_rd_data, 8'h00);

    // R4: mask bit 3 alone enables nothing; a masked strobe stays pending
    wreg(0, 8'h08);
    host_addr = 3'd0; step(); chk("R4", host_rd_data, 8'h08);
    pulse_evt(2);
    step(3); chk("R4", irq_req, 0);
    wreg(0, 8'h04);
    step(); chk("R4", irq_req, 1);
    chk("R5", irq_bid, {3'd2, 3'd2});

    // R3: latched until ack; strobe wins over same-cycle ack
    step(5); chk("R3", irq_req, 1);
    brk_evt = 1; irq_ack = 8'h04; step(); brk_evt = 0; irq_ack = 0;
    step(2); chk("R3", irq_req, 1);
    ack(8'h04); step(); chk("R3", irq_req, 0);

    // R2: level sources follow their input
    wreg(0, 8'h03);
    tx_svc = 1; step(2); chk("R2", irq_bid, 6'd0); chk("R2", irq_req, 1);
    rx_svc = 1; step(2); chk("R6", irq_bid, 6'd1);
    tx_svc = 0; rx_svc = 0; step(2); chk("R2", irq_req, 0);

    // R6/R5: priority across all latched classes
    wreg(0, 8'hFF);
    pulse_evt(2); pulse_evt(4); pulse_evt(5); pulse_evt(7);
    step(); chk("R6", irq_bid, {3'd5, 3'd7});
    ack(8'h80); step(); chk("R6", irq_bid, {3'd6, 3'd5});
    ack(8'h20); step(); chk("R5", irq_bid, {3'd3, 3'd4});
    ack(8'h10); step(); chk("R5", irq_bid, {3'd2, 3'd2});
    ack(8'h04); step(); chk("R9", irq_req, 0);

    // R8: activity restarts the count; fire once after 64 idle ticks
    wreg(0, 8'h40);
    bit_tick = 1; step(40);
    rx_activity = 1; step(); rx_activity = 0;
    step(63); step(); chk("R8", irq_req, 0);
    step(); bit_tick = 0; step(); chk("R8", irq_req, 1);
    chk("R8", irq_bid, 6'd6);
    ack(8'h40); bit_tick = 1; step(100); bit_tick = 0; step(2);
    chk("R8", irq_req, 0);
    rx_activity = 1; bit_tick = 1; step(); rx_activity = 0;
    step(64); bit_tick = 0; step(2); chk("R8", irq_req, 1);
    ack(8'h40); step(2);

    // R1: mid-run reset clears pending state
    pulse_evt(7); rst = 1; step(2); rst = 0; step(); wreg(0, 8'hFF); step(2);
    chk("R1", irq_req, 0);
    step(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule